// File: doc/BRIEF.md
# Phase-Aligned Divider Sync Controller

This block merges every source that may ask for a clock-output resynchronization into one internal hold signal and drives a bank of programmable channel dividers from it. The sources are three asynchronous active-low pins (a manual sync pin, a chip reset pin and a power-down pin), three software control bits held behind a shadow/update register scheme, and a calibration-busy flag. While any source is active, every divider output is parked low. Once all sources go quiet, a fixed release count runs, and then every channel restarts on the same clock edge, so that outputs with different ratios begin in phase.

Everything runs on the fast divider input clock `clk`. A synchronous active-high `rst` starts the block in the hold state, so a power-up sync happens without any request. Software writes land in shadow registers and reach the active copy only through an update strobe. This covers both the sync control bits and the per-channel ratios.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: While `rst` is high, `sync_active` is 1 and `div_clk` is all zero. Take the first rising edge with `rst` low as edge 1. With no request present, `sync_active` drops at edge RELEASE_CYCLES and all outputs go high at edge RELEASE_CYCLES+1.
- R2: Any active request forces `sync_active` to 1 at the next edge. While `sync_active` is 1, and on the edge after it, every `div_clk` bit is 0.
- R3: Take as edge 1 the first edge at which the merged request is sampled inactive. `sync_active` falls at edge RELEASE_CYCLES and the outputs first rise at edge RELEASE_CYCLES+1.
- R4: A low level on `sync_pin_n`, `reset_pin_n` or `pdn_pin_n` is a request. Each pin passes through a SYNC_STAGES-flop synchronizer. With the default of two stages, the outputs rise at the (RELEASE_CYCLES+3)-th edge after the pin returns high.
- R5: The register map is as follows. Address 0 is the shadow control register: bit 0 soft sync, bit 1 soft reset, bit 2 distribution power-down. Address 2+i is the shadow half-period of channel i. Writes to these have no effect on the outputs until address 1 is written with bit 0 set. That write is sampled at edge 1, and all shadows are copied to the active copy at edge 2. A write to address 1 with bit 0 clear copies nothing.
- R6: Any of the three active control bits set is a request. Releasing it by clearing the bit and then strobing an update gives a first output rise at edge RELEASE_CYCLES+3, counted from the update write.
- R7: A channel with active half-period H (0 treated as 1) is high for H cycles and then low for H cycles, starting high on the release edge.
- R8: All channels rise together on the release edge, whatever their ratios.
- R9: A request that appears during the release count, including on its final cycle, keeps `sync_active` at 1. The count then restarts from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pin_n | input | 1 | Asynchronous manual sync request, active low |
| reset_pin_n | input | 1 | Asynchronous chip reset request, active low |
| pdn_pin_n | input | 1 | Asynchronous power-down request, active low |
| cal_busy | input | 1 | Calibration in progress, synchronous to clk |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | RATIO_W | Register write data |
| div_clk | output | NUM_CH | Divided channel clocks |
| sync_active | output | 1 | High while outputs are held static |

## Verification
Two things can coincide on one edge: the release counter reaching its final count, and a fresh request arriving. If the request were ignored, the outputs would restart early. The bench provokes this by dropping the calibration flag and raising it again exactly RELEASE_CYCLES-1 edges later, so that it is sampled on the edge where the hold would end. The bench then checks two things: `sync_active` is still 1 with all outputs low after that edge, and the next release takes the full RELEASE_CYCLES+1 edges again.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;

    // Software control bits; bit 0 soft sync, bit 1 soft reset, bit 2 distribution power-down
    typedef struct packed {
        logic dist_pd;
        logic soft_rst;
        logic soft_sync;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Register addresses
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_UPDATE = 1;
    localparam int ADDR_RATIO0 = 2;

    // Asynchronous request pins, bit index into the synchronizer bank
    typedef enum int {
        PIN_SYNC  = 0,
        PIN_RESET = 1,
        PIN_PDN   = 2
    } pin_e;

    localparam int NUM_PINS = 3;

    typedef enum logic {
        REL_RUN  = 1'b0,
        REL_HOLD = 1'b1
    } rel_state_e;

    function automatic logic ctrl_request(input ctrl_t c);
        return c.dist_pd | c.soft_rst | c.soft_sync;
    endfunction

endpackage

// File: rtl/sync_ctrl_pin_sync.sv
module sync_ctrl_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] pin_q_n
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], pin_n[b]};
                end
            end
            assign pin_q_n[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sync_ctrl_regs.sv
module sync_ctrl_regs
    import clkdiv_sync_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int ADDR_W  = 4,
    parameter int RATIO_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [RATIO_W-1:0]             wdata,
    output ctrl_t                          act_ctrl,
    output logic [NUM_CH-1:0][RATIO_W-1:0] act_ratio
);

    ctrl_t                          sh_ctrl;
    logic [NUM_CH-1:0][RATIO_W-1:0] sh_ratio;
    logic                           upd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ctrl  <= '0;
            act_ctrl <= '0;
            upd_pend <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                sh_ratio[c]  <= RATIO_W'(1);
                act_ratio[c] <= RATIO_W'(1);
            end
        end else begin
            if (upd_pend) begin
                act_ctrl  <= sh_ctrl;
                act_ratio <= sh_ratio;
            end
            // strobe lives for exactly one cycle
            upd_pend <= we && (addr == ADDR_W'(ADDR_UPDATE)) && wdata[0];
            if (we && (addr == ADDR_W'(ADDR_CTRL))) begin
                sh_ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (we && (addr == ADDR_W'(ADDR_RATIO0 + c))) begin
                    sh_ratio[c] <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/sync_ctrl_release.sv
module sync_ctrl_release
    import clkdiv_sync_pkg::*;
#(
    parameter int RELEASE_CYCLES = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic hold
);

    localparam int DLY_W = $clog2(RELEASE_CYCLES + 1);

    rel_state_e       state;
    logic [DLY_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= REL_HOLD;
            dly   <= '0;
        end else if (req) begin
            state <= REL_HOLD;
            dly   <= '0;
        end else if (state == REL_HOLD) begin
            if (dly == DLY_W'(RELEASE_CYCLES - 1)) begin
                state <= REL_RUN;
                dly   <= '0;
            end else begin
                dly <= dly + 1'b1;
            end
        end
    end

    assign hold = (state == REL_HOLD);

endmodule

// File: rtl/sync_ctrl_divider.sv
module sync_ctrl_divider #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);

    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] cnt;

    assign half = (ratio == '0) ? RATIO_W'(1) : ratio;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            // park at the terminal count so the first running edge rises
            cnt     <= half - 1'b1;
            clk_out <= 1'b0;
        end else if (cnt >= half - 1'b1) begin
            cnt     <= '0;
            clk_out <= ~clk_out;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
    import clkdiv_sync_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int ADDR_W         = 4,
    parameter int RATIO_W        = 8,
    parameter int RELEASE_CYCLES = 15,
    parameter int SYNC_STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_pin_n,
    input  logic               reset_pin_n,
    input  logic               pdn_pin_n,
    input  logic               cal_busy,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [RATIO_W-1:0] reg_wdata,
    output logic [NUM_CH-1:0]  div_clk,
    output logic               sync_active
);

    logic [NUM_PINS-1:0]            pin_raw_n;
    logic [NUM_PINS-1:0]            pin_q_n;
    ctrl_t                          act_ctrl;
    logic [NUM_CH-1:0][RATIO_W-1:0] act_ratio;
    logic                           req_any;
    logic                           hold;

    assign pin_raw_n[PIN_SYNC]  = sync_pin_n;
    assign pin_raw_n[PIN_RESET] = reset_pin_n;
    assign pin_raw_n[PIN_PDN]   = pdn_pin_n;

    sync_ctrl_pin_sync #(
        .WIDTH (NUM_PINS),
        .STAGES(SYNC_STAGES)
    ) u_pins (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (pin_raw_n),
        .pin_q_n(pin_q_n)
    );

    sync_ctrl_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .RATIO_W(RATIO_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .act_ctrl (act_ctrl),
        .act_ratio(act_ratio)
    );

    assign req_any = (|(~pin_q_n)) | ctrl_request(act_ctrl) | cal_busy;

    sync_ctrl_release #(
        .RELEASE_CYCLES(RELEASE_CYCLES)
    ) u_release (
        .clk (clk),
        .rst (rst),
        .req (req_any),
        .hold(hold)
    );

    assign sync_active = hold;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            sync_ctrl_divider #(
                .RATIO_W(RATIO_W)
            ) u_div (
                .clk    (clk),
                .rst    (rst),
                .hold   (hold),
                .ratio  (act_ratio[ch]),
                .clk_out(div_clk[ch])
            );
        end
    endgenerate

endmodule

// File: rtl/clkdiv_sync_ctrl_chk.sv
module clkdiv_sync_ctrl_chk
    import clkdiv_sync_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int ADDR_W         = 4,
    parameter int RELEASE_CYCLES = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cal_busy,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_upd_bit,
    input logic              req_any,
    input ctrl_t             act_ctrl,
    input logic              sync_active,
    input logic [NUM_CH-1:0] div_clk
);

    localparam int QW = $clog2(RELEASE_CYCLES + 2);

    // consecutive edges with the merged request inactive
    logic [QW-1:0] quiet;
    always_ff @(posedge clk) begin
        if (rst || req_any) begin
            quiet <= '0;
        end else if (quiet != QW'(RELEASE_CYCLES + 1)) begin
            quiet <= quiet + 1'b1;
        end
    end

    logic upd_write;
    assign upd_write = reg_we && (reg_addr == ADDR_W'(ADDR_UPDATE)) && reg_upd_bit;

    a_r2_calib_holds: assert property (@(posedge clk) disable iff (rst)
        cal_busy |=> sync_active);

    a_r2_outputs_static: assert property (@(posedge clk) disable iff (rst)
        sync_active |=> (div_clk == '0));

    a_r3_release_delay: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_active) |-> (quiet == QW'(RELEASE_CYCLES)));

    a_r8_aligned_start: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_active) |=> (div_clk == '1));

    a_r9_request_restarts: assert property (@(posedge clk) disable iff (rst)
        req_any |=> sync_active);

    a_r5_update_gates_ctrl: assert property (@(posedge clk) disable iff (rst)
        (act_ctrl != $past(act_ctrl)) |-> $past(upd_write, 2));

endmodule

bind clkdiv_sync_ctrl clkdiv_sync_ctrl_chk #(
    .NUM_CH        (NUM_CH),
    .ADDR_W        (ADDR_W),
    .RELEASE_CYCLES(RELEASE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cal_busy   (cal_busy),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_upd_bit(reg_wdata[0]),
    .req_any    (req_any),
    .act_ctrl   (act_ctrl),
    .sync_active(sync_active),
    .div_clk    (div_clk)
);

// File: tb/clkdiv_sync_ctrl_bench.sv
module clkdiv_sync_ctrl_bench;
    import clkdiv_sync_pkg::*;

    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 4;
    localparam int RATIO_W = 8;
    localparam int RC      = 15;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sync_pin_n = 1'b1;
    logic                reset_pin_n = 1'b1;
    logic                pdn_pin_n = 1'b1;
    logic                cal_busy = 1'b0;
    logic                reg_we = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [RATIO_W-1:0]  reg_wdata = '0;
    logic [NUM_CH-1:0]   div_clk;
    logic                sync_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    clkdiv_sync_ctrl #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W),
        .RELEASE_CYCLES(RC), .SYNC_STAGES(2)
    ) u_clkdiv_sync_ctrl (
        .clk(clk), .rst(rst), .sync_pin_n(sync_pin_n), .reset_pin_n(reset_pin_n),
        .pdn_pin_n(pdn_pin_n), .cal_busy(cal_busy), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .div_clk(div_clk),
        .sync_active(sync_active)
    );

    // {source[7:4], extra release edges beyond RC[3:0]}
    // sources: 0 calib, 1 sync pin, 2 reset pin, 3 pdn pin, 4 soft sync, 5 soft reset, 6 dist pd
    localparam logic [7:0] SRC_VEC [7] = '{8'h01, 8'h13, 8'h23, 8'h33, 8'h43, 8'h53, 8'h63};

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = RATIO_W'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // call at a falling edge; the next rising edge counts as edge 1
    task automatic drive_src(input int s, input bit on);
        case (s)
            0: cal_busy    = on;
            1: sync_pin_n  = !on;
            2: reset_pin_n = !on;
            3: pdn_pin_n   = !on;
            default: begin
                reg_write(ADDR_CTRL, on ? (1 << (s - 4)) : 0);
                if (on) begin
                    reg_write(ADDR_UPDATE, 1);
                end else begin
                    reg_we    = 1'b1;
                    reg_addr  = ADDR_W'(ADDR_UPDATE);
                    reg_wdata = RATIO_W'(1);
                end
            end
        endcase
    endtask

    task automatic measure(input int exp, input string tag);
        int n    = 0;
        int fall = 0;
        while (n < 200) begin
            @(posedge clk);
            #2;
            reg_we = 1'b0;
            n++;
            if (!sync_active && fall == 0) fall = n;
            if (div_clk != '0) break;
        end
        check(n == exp, {tag, " first output edge"}, n, exp);
        check(fall == exp - 1, {tag, " sync_active fall edge"}, fall, exp - 1);
        check(div_clk == '1, "R8 all channels rise together", int'(div_clk), (1 << NUM_CH) - 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sync_active == 1'b1, "R1 sync_active in reset", int'(sync_active), 1);
        check(div_clk == '0, "R1 outputs in reset", int'(div_clk), 0);
        rst = 1'b0;
        measure(RC + 1, "R1 power-up");

        // ratios 1..4 through shadows (R5, R7)
        for (int c = 0; c < NUM_CH; c++) reg_write(ADDR_RATIO0 + c, c + 1);
        reg_write(ADDR_UPDATE, 1);

        // table walk over every request source (R2, R3, R4, R6)
        for (int i = 0; i < 7; i++) begin
            int src   = int'(SRC_VEC[i][7:4]);
            int extra = int'(SRC_VEC[i][3:0]);
            @(negedge clk);
            drive_src(src, 1'b1);
            repeat (6) @(negedge clk);
            check(sync_active == 1'b1, $sformatf("R2 held, source %0d", src), int'(sync_active), 1);
            check(div_clk == '0, $sformatf("R2 static, source %0d", src), int'(div_clk), 0);
            @(negedge clk);
            drive_src(src, 1'b0);
            if (src == 0) measure(RC + extra, "R3 calib release");
            else if (src < 4) measure(RC + extra, "R4 pin release");
            else measure(RC + extra, "R6 soft bit release");
        end

        // R7 and R8: waveform of each ratio after release
        @(negedge clk);
        cal_busy = 1'b1;
        repeat (3) @(negedge clk);
        cal_busy = 1'b0;
        measure(RC + 1, "R3 release");
        for (int t = 0; t < 24; t++) begin
            logic [NUM_CH-1:0] exp_v;
            if (t > 0) begin
                @(posedge clk);
                #2;
            end
            for (int c = 0; c < NUM_CH; c++) exp_v[c] = ((t / (c + 1)) % 2) == 0;
            check(div_clk == exp_v, $sformatf("R7 R8 waveform t=%0d", t), int'(div_clk), int'(exp_v));
        end

        // R5: shadow write without a valid update strobe has no effect
        reg_write(ADDR_CTRL, 1);
        reg_write(ADDR_UPDATE, 0);
        repeat (4) @(negedge clk);
        check(sync_active == 1'b0, "R5 no update, no sync", int'(sync_active), 0);
        begin
            logic a, b;
            @(posedge clk); #2; a = div_clk[0];
            @(posedge clk); #2; b = div_clk[0];
            check(a != b, "R5 channel 0 keeps toggling", int'(b), int'(!a));
        end
        reg_write(ADDR_CTRL, 0);

        // R9: request mid-count restarts the release
        @(negedge clk);
        cal_busy = 1'b1;
        repeat (2) @(negedge clk);
        cal_busy = 1'b0;
        repeat (4) @(negedge clk);
        cal_busy = 1'b1;
        @(negedge clk);
        cal_busy = 1'b0;
        check(sync_active == 1'b1, "R9 held after mid-count request", int'(sync_active), 1);
        measure(RC + 1, "R9 restarted release");

        // R9: request on the final count cycle
        @(negedge clk);
        cal_busy = 1'b1;
        repeat (2) @(negedge clk);
        cal_busy = 1'b0;
        repeat (RC - 1) @(negedge clk);
        check(sync_active == 1'b1, "R9 still counting", int'(sync_active), 1);
        cal_busy = 1'b1;
        @(posedge clk);
        #2;
        check(sync_active == 1'b1, "R9 final-cycle request wins", int'(sync_active), 1);
        check(div_clk == '0, "R9 outputs stay static", int'(div_clk), 0);
        @(negedge clk);
        cal_busy = 1'b0;
        measure(RC + 1, "R9 late restart");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule